// File: doc/BRIEF.md
# Indirect MII Management Access Bridge

This block lets a host processor reach the management registers of PHYs over a two-wire serial management bus without running the bus protocol in software. The host sees two 32-bit registers: a command word and a data word. Writing the command word with its go/busy bit set starts one clause 22 management transaction. The transaction goes to the 5-bit PHY address and the 5-bit register index held in that word. The bit stays set while the transaction runs and clears by itself when it ends.

For a write, the host first places the 16-bit value in the data word and then issues the command. For a read, the host issues the command, polls until the busy bit drops, and then takes the result from the low half of the data word. The serial clock comes from the system clock divided by a parameter. The block drives the data line on the falling edge of that clock and samples it on the rising edge. During the turnaround and data phases of a read it releases the line so the PHY can drive it. A read from an address where no PHY answers returns all ones, because the idle line floats high.

Top module: `mii_bridge`

## Requirements
- R1: After reset the command word reads 0, the data word reads 0, `mdc` is low and `mdio_oe` is low.
- R2: The command word holds the PHY address in bits 15:11, the register index in bits 10:6, the direction in bit 1 (1 = write, 0 = read) and busy in bit 0. Bits 31:16 and 5:2 read 0. Readback returns the stored fields.
- R3: Writing the command word with bit 0 = 1 while idle starts a transaction. Busy then reads 1 for exactly 64 × `MDC_DIV` clock cycles and returns to 0 without further host action.
- R4: Each transaction is 64 bit slots, sent MSB first: 32 ones, start 01, opcode (10 read, 01 write), PHY address, register index, turnaround and 16 data bits. A write sends turnaround 10 followed by the low 16 bits of the data word.
- R5: During the turnaround and data slots of a read (slots 46 to 63) `mdio_oe` is low. On completion the data word holds the 16 bits sampled in slots 48 to 63, with bits 31:16 reading 0.
- R6: A read from a PHY address with no responder (line pulled high) returns 0xFFFF in the data word.
- R7: While busy, a host write to the command word or to the data word is ignored. The running transaction, its fields and its result are unaffected.
- R8: `mdc` has a period of `MDC_DIV` clocks: low for the first half of each slot and high for the second half. It stays low when idle. `mdio_o` changes only in the cycle where `mdc` falls, and input data is sampled on the cycle where `mdc` rises.
- R9: Writing the command word with bit 0 = 0 while idle updates the stored fields and starts no transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 1 | Register select: 1 = command word, 0 = data word |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Readback of the register picked by `host_sel` |
| mdc | output | 1 | Management serial clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in (pulled high off chip) |

## Verification
The hardest case to reach from the ports is a host write that arrives in the middle of a read. It must leave the serial frame, the stored fields and the eventual result untouched. The stimulus launches a read to a responding PHY and waits about a hundred cycles into the preamble. It then writes a different command word and a different data value. Afterwards it compares the captured frame header and the returned data with what the original command implies. The absent-PHY read relies on the bench responder staying silent, so the design samples only the pull-up. The bench also monitors bus contention in case both sides drive during turnaround.

// File: rtl/mii_pkg.sv
package mii_pkg;

    localparam int unsigned PRE_BITS   = 32;
    localparam int unsigned FRAME_BITS = 64;
    localparam int unsigned TA_SLOT    = 46;
    localparam int unsigned DATA_SLOT  = 48;
    localparam int unsigned SLOT_W     = $clog2(FRAME_BITS);
    localparam int unsigned BUSY_BIT   = 0;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] SOF      = 2'b01;
    localparam logic [1:0] TA_DRIVE = 2'b10;

    localparam logic SEL_DATA = 1'b0;
    localparam logic SEL_CMD  = 1'b1;

    typedef struct packed {
        logic [4:0] phy;
        logic [4:0] regi;
        logic       wr;
    } mii_cmd_t;

    function automatic mii_cmd_t unpack_cmd(input logic [31:0] w);
        mii_cmd_t c;
        c.phy  = w[15:11];
        c.regi = w[10:6];
        c.wr   = w[1];
        return c;
    endfunction

    function automatic logic [31:0] pack_cmd(input mii_cmd_t c, input logic busy);
        return {16'h0000, c.phy, c.regi, 4'h0, c.wr, busy};
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(input mii_cmd_t c,
                                                          input logic [15:0] d);
        logic [1:0] op;
        op = c.wr ? OP_WRITE : OP_READ;
        return {{PRE_BITS{1'b1}}, SOF, op, c.phy, c.regi, TA_DRIVE, d};
    endfunction

endpackage

// File: rtl/mii_mdc_gen.sv
module mii_mdc_gen #(
    parameter int unsigned DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic slot_end
);
    localparam int unsigned HALF = DIV / 2;
    localparam int unsigned CW   = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign rise_tick = run && (cnt == CW'(HALF - 1));
    assign slot_end  = run && (cnt == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= slot_end ? '0 : cnt + CW'(1);
            if (rise_tick)
                mdc <= 1'b1;
            else if (slot_end)
                mdc <= 1'b0;
        end
    end
endmodule

// File: rtl/mii_frame_engine.sv
module mii_frame_engine
    import mii_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  mii_cmd_t          start_cmd,
    input  logic [15:0]       start_data,
    input  logic              rise_tick,
    input  logic              slot_end,
    input  logic              mdio_i,
    output logic              active,
    output logic              is_rd,
    output logic [SLOT_W-1:0] slot,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [15:0]       rd_word
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_BITS - 1);

    logic [FRAME_BITS-1:0] shreg;
    logic [15:0]           rx;

    assign done    = active && slot_end && (slot == LAST_SLOT);
    assign mdio_o  = shreg[FRAME_BITS-1];
    assign mdio_oe = active && !(is_rd && (slot >= SLOT_W'(TA_SLOT)));
    assign rd_word = rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            is_rd  <= 1'b0;
            slot   <= '0;
            shreg  <= '1;
            rx     <= '0;
        end else if (start) begin
            active <= 1'b1;
            is_rd  <= !start_cmd.wr;
            slot   <= '0;
            shreg  <= build_frame(start_cmd, start_data);
        end else if (active) begin
            if (rise_tick && is_rd && (slot >= SLOT_W'(DATA_SLOT)))
                rx <= {rx[14:0], mdio_i};
            if (slot_end) begin
                if (slot == LAST_SLOT) begin
                    active <= 1'b0;
                    shreg  <= '1;
                end else begin
                    slot  <= slot + SLOT_W'(1);
                    shreg <= {shreg[FRAME_BITS-2:0], 1'b1};
                end
            end
        end
    end
endmodule

// File: rtl/mii_host_regs.sv
module mii_host_regs
    import mii_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic        host_sel,
    input  logic [31:0] host_wdata,
    input  logic        busy,
    input  logic        done,
    input  logic        done_rd,
    input  logic [15:0] rd_word,
    output logic        start,
    output mii_cmd_t    start_cmd,
    output logic [15:0] wr_word,
    output logic [31:0] host_rdata
);
    mii_cmd_t    cmd_q;
    logic [15:0] data_q;
    logic        wr_ok;

    assign wr_ok     = host_we && !busy;
    assign start     = wr_ok && (host_sel == SEL_CMD) && host_wdata[BUSY_BIT];
    assign start_cmd = unpack_cmd(host_wdata);
    assign wr_word   = data_q;

    always_comb begin
        if (host_sel == SEL_CMD)
            host_rdata = pack_cmd(cmd_q, busy);
        else
            host_rdata = {16'h0000, data_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            data_q <= '0;
        end else begin
            if (wr_ok) begin
                if (host_sel == SEL_CMD)
                    cmd_q <= start_cmd;
                else
                    data_q <= host_wdata[15:0];
            end
            if (done && done_rd)
                data_q <= rd_word;
        end
    end
endmodule

// File: rtl/mii_bridge.sv
module mii_bridge
    import mii_pkg::*;
#(
    parameter int unsigned MDC_DIV = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic        host_sel,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              busy_w;
    logic              rd_w;
    logic [SLOT_W-1:0] slot_w;
    logic              start_w;
    mii_cmd_t          cmd_w;
    logic [15:0]       wr_word_w;
    logic [15:0]       rd_word_w;
    logic              done_w;
    logic              rise_w;
    logic              end_w;

    mii_host_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .busy       (busy_w),
        .done       (done_w),
        .done_rd    (rd_w),
        .rd_word    (rd_word_w),
        .start      (start_w),
        .start_cmd  (cmd_w),
        .wr_word    (wr_word_w),
        .host_rdata (host_rdata)
    );

    mii_mdc_gen #(.DIV(MDC_DIV)) u_mdc (
        .clk       (clk),
        .rst       (rst),
        .run       (busy_w),
        .mdc       (mdc),
        .rise_tick (rise_w),
        .slot_end  (end_w)
    );

    mii_frame_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .start      (start_w),
        .start_cmd  (cmd_w),
        .start_data (wr_word_w),
        .rise_tick  (rise_w),
        .slot_end   (end_w),
        .mdio_i     (mdio_i),
        .active     (busy_w),
        .is_rd      (rd_w),
        .slot       (slot_w),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .done       (done_w),
        .rd_word    (rd_word_w)
    );
endmodule

// File: rtl/mii_bridge_chk.sv
module mii_bridge_chk
    import mii_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic              busy,
    input logic              is_rd,
    input logic [SLOT_W-1:0] slot
);
    assert_ta_release_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && is_rd && slot >= SLOT_W'(TA_SLOT)) |-> !mdio_oe);

    assert_write_drive_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !is_rd) |-> mdio_oe);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));

    assert_edge_align_R8: assert property (@(posedge clk) disable iff (rst)
        (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));

    assert_full_frame_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(slot) == SLOT_W'(FRAME_BITS - 1)));
endmodule

bind mii_bridge mii_bridge_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .busy    (busy_w),
    .is_rd   (rd_w),
    .slot    (slot_w)
);

// File: tb/sim_mii_bridge.sv
`timescale 1ns/1ps
module sim_mii_bridge;
    localparam int unsigned DIV = 8;
    localparam logic [4:0] RESP_PHY = 5'd3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    always #5 clk = ~clk;

    mii_bridge #(.MDC_DIV(DIV)) u0 (
        .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // PHY responder model
    logic [15:0] phy_mem [32];
    logic [15:0] exp_mem [32];
    logic [63:0] cap = '0;
    int          bitcnt = 100;
    logic        drv_en = 1'b0;
    logic        drv_val = 1'b1;
    bit          clash = 0;
    realtime     last_rise = 0, per = 0, hi = 0;

    assign mdio_i = mdio_oe ? mdio_o : (drv_en ? drv_val : 1'b1);

    always @(posedge mdc) begin
        per = $realtime - last_rise;
        last_rise = $realtime;
        if (mdio_oe && drv_en) clash = 1;
        if (bitcnt < 64) cap[63 - bitcnt] = mdio_i;
        bitcnt = bitcnt + 1;
        if (bitcnt == 64 && cap[29:28] == 2'b01 && cap[27:23] == RESP_PHY)
            phy_mem[cap[22:18]] = cap[15:0];
    end

    always @(negedge mdc) begin
        hi = $realtime - last_rise;
        if (bitcnt >= 47 && bitcnt <= 63 && cap[29:28] == 2'b10 && cap[27:23] == RESP_PHY) begin
            drv_en  = 1'b1;
            drv_val = (bitcnt == 47) ? 1'b0 : phy_mem[cap[22:18]][15 - (bitcnt - 48)];
        end else begin
            drv_en = 1'b0;
        end
    end

    // scoreboard queues
    logic [15:0] exp_q [$];
    logic [15:0] act_q [$];
    string       tag_q [$];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin : monitor
        forever begin
            wait (act_q.size() > 0);
            begin
                logic [15:0] a, e;
                string t;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {48'h0, a}, {48'h0, e});
            end
        end
    end

    task automatic host_write(input logic sel, input logic [31:0] d);
        @(negedge clk);
        host_sel = sel; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input logic sel, output logic [31:0] d);
        host_sel = sel;
        #1 d = host_rdata;
    endtask

    function automatic logic [31:0] cmd_word(input logic [4:0] p, input logic [4:0] r,
                                             input logic wr, input logic go);
        return {16'h0, p, r, 4'h0, wr, go};
    endfunction

    function automatic logic [63:0] exp_frame(input logic wr, input logic [4:0] p,
                                              input logic [4:0] r, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), p, r, 2'b10, d};
    endfunction

    task automatic wait_idle(output int n);
        logic [31:0] v;
        n = 0;
        forever begin
            host_read(1'b1, v);
            if (!v[0]) break;
            n++;
            @(negedge clk);
        end
    endtask

    // full transaction through the host registers
    task automatic mii_op(input logic wr, input logic [4:0] p, input logic [4:0] r,
                          input logic [15:0] d);
        int n;
        logic [31:0] v;
        if (wr) host_write(1'b0, {16'h0, d});
        bitcnt = 0;
        host_write(1'b1, cmd_word(p, r, wr, 1'b1));
        wait_idle(n);
        check("R3 busy length", n, 64 * DIV);
        repeat (DIV) @(negedge clk);
        if (wr) begin
            check("R4 write frame", cap, exp_frame(1'b1, p, r, d));
            if (p == RESP_PHY) exp_mem[r] = d;
        end else begin
            check("R4 read header", {18'h0, cap[63:18]}, {18'h0, exp_frame(1'b0, p, r, 16'h0) >> 18});
            host_read(1'b0, v);
            check("R5 upper half zero", {48'h0, v[31:16]}, 64'h0);
            act_q.push_back(v[15:0]);
            exp_q.push_back((p == RESP_PHY) ? exp_mem[r] : 16'hFFFF);
            tag_q.push_back((p == RESP_PHY) ? "R5 read data" : "R6 absent phy");
        end
    endtask

    initial begin : watchdog
        #2ms;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : driver
        logic [31:0] v;
        int n;
        for (int i = 0; i < 32; i++) begin
            phy_mem[i] = 16'hA500 ^ (16'h0101 * 16'(i));
            exp_mem[i] = phy_mem[i];
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        host_read(1'b1, v); check("R1 cmd reset", v, 0);
        host_read(1'b0, v); check("R1 data reset", v, 0);
        check("R1 mdc/oe low", {mdc, mdio_oe}, 0);

        // R9 fields only, no launch; R2 field positions
        bitcnt = 100;
        host_write(1'b1, cmd_word(5'd5, 5'd9, 1'b1, 1'b0) | 32'hFFFF_003C);
        repeat (20) @(negedge clk);
        host_read(1'b1, v);
        check("R2 field readback", v, cmd_word(5'd5, 5'd9, 1'b1, 1'b0));
        check("R9 no cycle", {mdc, mdio_oe, 31'(bitcnt)}, {2'b00, 31'd100});

        // write then read back via responder
        mii_op(1'b1, RESP_PHY, 5'd4, 16'h1234);
        host_read(1'b0, v); check("R4 data word kept after write", v, 32'h1234);
        mii_op(1'b0, RESP_PHY, 5'd4, 16'h0);
        check("R8 mdc period", 64'(int'(per)), DIV * 10);
        check("R8 mdc high time", 64'(int'(hi)), DIV * 5);
        mii_op(1'b0, RESP_PHY, 5'd7, 16'h0);
        mii_op(1'b1, RESP_PHY, 5'd31, 16'hFFFF);
        mii_op(1'b0, RESP_PHY, 5'd31, 16'h0);
        mii_op(1'b1, RESP_PHY, 5'd0, 16'h0001);
        mii_op(1'b0, RESP_PHY, 5'd0, 16'h0);

        // R6 nobody at address 9 or 0
        mii_op(1'b0, 5'd9, 5'd2, 16'h0);
        mii_op(1'b1, 5'd9, 5'd2, 16'h5555);
        mii_op(1'b0, 5'd0, 5'd1, 16'h0);

        // R7 host writes during a running read
        bitcnt = 0;
        host_write(1'b1, cmd_word(RESP_PHY, 5'd7, 1'b0, 1'b1));
        repeat (100) @(negedge clk);
        host_read(1'b1, v);
        check("R2 busy visible", v, cmd_word(RESP_PHY, 5'd7, 1'b0, 1'b1));
        host_write(1'b1, cmd_word(5'd9, 5'd1, 1'b1, 1'b1));
        host_write(1'b0, 32'h0000_BEEF);
        wait_idle(n);
        repeat (DIV) @(negedge clk);
        host_read(1'b1, v);
        check("R7 cmd fields kept", v, cmd_word(RESP_PHY, 5'd7, 1'b0, 1'b0));
        check("R7 frame header kept", {18'h0, cap[63:18]},
              {18'h0, exp_frame(1'b0, RESP_PHY, 5'd7, 16'h0) >> 18});
        host_read(1'b0, v);
        act_q.push_back(v[15:0]);
        exp_q.push_back(exp_mem[7]);
        tag_q.push_back("R7 result kept");

        check("R5 no bus contention", {63'h0, clash}, 0);
        wait (act_q.size() == 0);
        #1;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule